// File: doc/BRIEF.md
# Scan-Chain Hibernate Controller

This always-on controller lets a power-gated domain be switched off without retention flops. When the power controller asks for a save, the block turns on the domain's scan mode. It shifts the whole chain out and packs the bits into 32-bit words. Each full word goes to on-chip memory as a bus write. A CRC-32 runs over the words as they are stored, and the finished checksum is written right after the last data word.

When the power controller asks for a restore, the block reads the same words back and shifts their bits into the chain in the order they left it. It also recomputes the CRC over the words it reads. At the end it reads the stored checksum and compares it with the new one. Any difference raises a corruption flag, which reports a soft error that hit the memory image while the domain was dark. Save and restore time grows with the chain length. The memory port may stall at any time, and scan shifting pauses while a transaction is pending, so no bit is lost.

Top module: `scan_hibernate_ctrl`

## Requirements
- R1: After reset, `ack`, `scanEn`, `shiftEn`, `memReq` and `crcErr` are all low.
- R2: From the cycle a request is accepted until the operation finishes, `scanEn` is high. Each save and each restore gives exactly CHAIN_LEN cycles with `shiftEn` high, and `shiftEn` is high only while `scanEn` is high.
- R3: During a save, the bit seen on `fromChain` in shift cycle k (k counting from 0) is stored in bit k mod 32 of the word at address BASE_ADDR + k/32. Bits of the final word past the chain end are stored as 0.
- R4: During a save, the word written to BASE_ADDR + ceil(CHAIN_LEN/32) is a CRC-32 over the data words in address order. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF, processes each word least significant bit first, and is inverted at the end.
- R5: During a restore, `toChain` presents the bits of the stored words in the same order as R3, one per shift cycle. A chain that shifts toward bit 0 therefore ends up holding exactly the state it had before the save.
- R6: `crcErr` goes high at the end of a restore when the stored checksum differs from the one recomputed over the read words, and stays low when they match. It is cleared when the next operation is accepted and stays low while `scanEn` is high.
- R7: A memory request holds `memReq`, `memWrite`, `memAddr` and `memWData` steady until the cycle in which `memReady` is high. `shiftEn` is never high while `memReq` is high.
- R8: `ack` rises only after the last memory transaction of the operation completes. It stays high, with `scanEn` low and `crcErr` steady, while either request is still high. It falls in the cycle after both requests are low.
- R9: When `saveReq` and `restoreReq` are both high in an idle cycle, a save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| saveReq | input | 1 | Request to save the domain state |
| restoreReq | input | 1 | Request to restore the domain state |
| ack | output | 1 | Operation complete; held until both requests drop |
| scanEn | output | 1 | Scan mode enable to the gated domain |
| shiftEn | output | 1 | Shift clock enable for the scan chain |
| toChain | output | 1 | Serial data into the scan chain |
| fromChain | input | 1 | Serial data out of the scan chain |
| memReq | output | 1 | Memory transaction request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word address |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data, valid in the cycle `memReady` is high |
| memReady | input | 1 | Transaction accepted this cycle |
| crcErr | output | 1 | Restored image failed its checksum |

## Verification
Two things can land in the same idle cycle: a save request and a restore request. They also overlap in the done phase, where the requests are released while the error flag and `ack` must hold. The bench raises both requests on one edge after filling memory with a sentinel. It judges the outcome by finding the packed chain image and its checksum in memory, which shows that the save won. It then keeps both requests high for several cycles and checks each cycle that `ack` and `crcErr` do not move, and finally checks that `ack` falls one cycle after release. Memory stalls are drawn at random, always-ready and rarely-ready runs are mixed in, and deliberate bit flips in data and checksum words test the error path.

// File: rtl/hib_pkg.sv
package hib_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SV_SHIFT, ST_SV_WRITE, ST_SV_CRC,
    ST_RS_READ, ST_RS_SHIFT, ST_RS_CHECK, ST_DONE
  } hibState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // new operation: clear word, seed CRC, clear error
    logic capture;  // store fromChain at current bit position
    logic load;     // load word from memory read data
    logic crcWr;    // fold buffered word into CRC
    logic crcRd;    // fold read data into CRC
    logic clrWord;  // clear word buffer
    logic drive;    // drive buffered bit onto chain input
    logic selCrc;   // write data is final checksum
    logic check;    // compare read data with checksum
  } hibStrobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crc, input logic [31:0] data);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 32; i++) begin
      c = (c[0] ^ data[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hib_dp.sv
module hib_dp
  import hib_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h100,
  parameter int unsigned IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hibStrobe_t        str,
  input  logic [4:0]        bitPos,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              fromChain,
  input  logic [31:0]       memRData,
  output logic              toChain,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  output logic              crcErr
);

  logic [31:0] wordBuf;
  logic [31:0] crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordBuf <= '0;
      crcReg  <= CRC_SEED;
      crcErr  <= 1'b0;
    end else if (str.start) begin
      wordBuf <= '0;
      crcReg  <= CRC_SEED;
      crcErr  <= 1'b0;
    end else begin
      if (str.capture) wordBuf[bitPos] <= fromChain;
      if (str.load)    wordBuf <= memRData;
      if (str.clrWord) wordBuf <= '0;
      if (str.crcWr)   crcReg <= crcStep(crcReg, wordBuf);
      if (str.crcRd)   crcReg <= crcStep(crcReg, memRData);
      if (str.check)   crcErr <= (memRData != ~crcReg);
    end
  end

  assign toChain  = str.drive ? wordBuf[bitPos] : 1'b0;
  assign memAddr  = ADDR_W'(BASE_ADDR) + ADDR_W'(wordIdx);
  assign memWData = str.selCrc ? ~crcReg : wordBuf;

endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 100,
  parameter int unsigned NWORDS    = 4,
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             saveReq,
  input  logic             restoreReq,
  input  logic             memReady,
  output hibStrobe_t       str,
  output logic [4:0]       bitPos,
  output logic [IDX_W-1:0] wordIdx,
  output logic             scanEn,
  output logic             shiftEn,
  output logic             memReq,
  output logic             memWrite,
  output logic             ack
);

  hibState_t state, nxt;
  logic [CNT_W-1:0] bitCnt;
  logic lastBit, wordEnd, lastWord;

  assign lastBit  = (bitCnt == CNT_W'(CHAIN_LEN - 1));
  assign wordEnd  = (bitPos == 5'd31) || lastBit;
  assign lastWord = (wordIdx == IDX_W'(NWORDS - 1));
  assign scanEn   = (state != ST_IDLE) && (state != ST_DONE);

  always_comb begin
    nxt      = state;
    str      = '0;
    shiftEn  = 1'b0;
    memReq   = 1'b0;
    memWrite = 1'b0;
    ack      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (saveReq) begin
          str.start = 1'b1;
          nxt = ST_SV_SHIFT;
        end else if (restoreReq) begin
          str.start = 1'b1;
          nxt = ST_RS_READ;
        end
      end
      ST_SV_SHIFT: begin
        shiftEn = 1'b1;
        str.capture = 1'b1;
        if (wordEnd) nxt = ST_SV_WRITE;
      end
      ST_SV_WRITE: begin
        memReq = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          str.crcWr = 1'b1;
          str.clrWord = 1'b1;
          nxt = lastWord ? ST_SV_CRC : ST_SV_SHIFT;
        end
      end
      ST_SV_CRC: begin
        memReq = 1'b1;
        memWrite = 1'b1;
        str.selCrc = 1'b1;
        if (memReady) nxt = ST_DONE;
      end
      ST_RS_READ: begin
        memReq = 1'b1;
        if (memReady) begin
          str.load = 1'b1;
          str.crcRd = 1'b1;
          nxt = ST_RS_SHIFT;
        end
      end
      ST_RS_SHIFT: begin
        shiftEn = 1'b1;
        str.drive = 1'b1;
        if (wordEnd) nxt = lastWord ? ST_RS_CHECK : ST_RS_READ;
      end
      ST_RS_CHECK: begin
        memReq = 1'b1;
        if (memReady) begin
          str.check = 1'b1;
          nxt = ST_DONE;
        end
      end
      ST_DONE: begin
        ack = 1'b1;
        if (!saveReq && !restoreReq) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      bitPos  <= '0;
      wordIdx <= '0;
    end else begin
      state <= nxt;
      if (str.start) begin
        bitCnt  <= '0;
        bitPos  <= '0;
        wordIdx <= '0;
      end else begin
        if (shiftEn) begin
          bitCnt <= bitCnt + 1'b1;
          bitPos <= bitPos + 5'd1;
        end
        if ((state == ST_SV_WRITE && memReady) || (state == ST_RS_SHIFT && wordEnd))
          wordIdx <= wordIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_hibernate_ctrl.sv
module scan_hibernate_ctrl
  import hib_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 100,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveReq,
  input  logic              restoreReq,
  output logic              ack,
  output logic              scanEn,
  output logic              shiftEn,
  output logic              toChain,
  input  logic              fromChain,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memReady,
  output logic              crcErr
);

  localparam int unsigned NWORDS = (CHAIN_LEN + WORD_W - 1) / WORD_W;
  localparam int unsigned CNT_W  = $clog2(CHAIN_LEN + 1);
  localparam int unsigned IDX_W  = $clog2(NWORDS + 2);

  hibStrobe_t       str;
  logic [4:0]       bitPos;
  logic [IDX_W-1:0] wordIdx;

  hib_ctrl #(
    .CHAIN_LEN(CHAIN_LEN), .NWORDS(NWORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .memReady(memReady), .str(str), .bitPos(bitPos), .wordIdx(wordIdx),
    .scanEn(scanEn), .shiftEn(shiftEn), .memReq(memReq), .memWrite(memWrite),
    .ack(ack)
  );

  hib_dp #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .bitPos(bitPos), .wordIdx(wordIdx),
    .fromChain(fromChain), .memRData(memRData), .toChain(toChain),
    .memAddr(memAddr), .memWData(memWData), .crcErr(crcErr)
  );

endmodule

// File: rtl/hib_chk.sv
module hib_chk #(
  parameter int unsigned CHAIN_LEN = 100,
  parameter int unsigned ADDR_W    = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              saveReq,
  input logic              restoreReq,
  input logic              ack,
  input logic              scanEn,
  input logic              shiftEn,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWData,
  input logic              memReady,
  input logic              crcErr
);

  int unsigned shiftCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftCnt <= 0;
    else if (ack)     shiftCnt <= 0;
    else if (shiftEn) shiftCnt <= shiftCnt + 1;
  end

  // R2
  shift_in_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> scanEn);

  // R2
  shift_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> shiftCnt == CHAIN_LEN);

  // R7
  no_shift_in_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && shiftEn));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWData)));

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && (saveReq || restoreReq)) |=> (ack && $stable(crcErr)));

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !scanEn && !memReq);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |-> !crcErr);

endmodule

bind scan_hibernate_ctrl hib_chk #(.CHAIN_LEN(CHAIN_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq), .ack(ack),
  .scanEn(scanEn), .shiftEn(shiftEn), .memReq(memReq), .memWrite(memWrite),
  .memAddr(memAddr), .memWData(memWData), .memReady(memReady), .crcErr(crcErr)
);

// File: tb/scan_hibernate_ctrl_test.sv
module scan_hibernate_ctrl_test;

  localparam int LEN  = 100;
  localparam int AW   = 16;
  localparam int BASE = 'h100;
  localparam int NW   = (LEN + 31) / 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, saveReq, restoreReq, ack, scanEn, shiftEn, toChain, fromChain;
  logic memReq, memWrite, memReady, crcErr;
  logic [AW-1:0] memAddr;
  logic [31:0] memWData, memRData;

  scan_hibernate_ctrl #(.CHAIN_LEN(LEN), .ADDR_W(AW), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq), .ack(ack),
    .scanEn(scanEn), .shiftEn(shiftEn), .toChain(toChain), .fromChain(fromChain),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memReady(memReady), .crcErr(crcErr)
  );

  // memory and chain models
  logic [31:0] mem [0:NW];
  logic [LEN-1:0] chain, loadVal;
  logic fillGo = 0, corruptGo = 0, loadGo = 0;
  int corruptIdx = 0;
  logic [31:0] corruptMask = 0;
  int memIdx;
  int readyMode = 0;
  int shiftTotal = 0, viol = 0, badAddr = 0;
  logic prevStall = 0;
  logic [AW-1:0] prevAddr;
  logic [31:0] prevData;
  logic prevWr;

  assign memIdx    = int'(memAddr) - BASE;
  assign memRData  = (memIdx >= 0 && memIdx <= NW) ? mem[memIdx] : 32'hDEAD_BEEF;
  assign fromChain = chain[0];

  always @(posedge clk) begin
    if (fillGo) begin
      for (int i = 0; i <= NW; i++) mem[i] <= 32'hA5A5_5A5A;
    end else if (corruptGo) begin
      mem[corruptIdx] <= mem[corruptIdx] ^ corruptMask;
    end else if (memReq && memReady && memWrite && memIdx >= 0 && memIdx <= NW) begin
      mem[memIdx] <= memWData;
    end
  end

  always @(posedge clk) begin
    if (loadGo) chain <= loadVal;
    else if (shiftEn) chain <= {toChain, chain[LEN-1:1]};
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (shiftEn) shiftTotal <= shiftTotal + 1;
      if ((shiftEn || memReq) && !scanEn) viol <= viol + 1;
      if (shiftEn && memReq) viol <= viol + 1;
      if (prevStall && (!memReq || memAddr != prevAddr || memWData != prevData || memWrite != prevWr))
        viol <= viol + 1;
      if (memReq && memReady && (memIdx < 0 || memIdx > NW)) badAddr <= badAddr + 1;
      prevStall <= memReq && !memReady;
      prevAddr <= memAddr;
      prevData <= memWData;
      prevWr   <= memWrite;
    end
  end

  always @(negedge clk) begin
    case (readyMode)
      0: memReady <= 1'b1;
      1: memReady <= ($urandom % 2) == 0;
      default: memReady <= ($urandom % 8) == 0;
    endcase
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [LEN-1:0] p, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (w * 32 + b < LEN) r[b] = p[w * 32 + b];
    return r;
  endfunction

  function automatic logic [31:0] expCrc(input logic [LEN-1:0] p);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] d = expWord(p, w);
      for (int by = 0; by < 4; by++) begin
        c = c ^ {24'd0, d[by*8 +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  function automatic logic [LEN-1:0] rndPat();
    logic [LEN-1:0] p;
    for (int i = 0; i < LEN; i++) p[i] = 1'($urandom % 2);
    return p;
  endfunction

  task automatic pulse(ref logic go);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic setChain(input logic [LEN-1:0] v);
    loadVal = v;
    pulse(loadGo);
  endtask

  task automatic waitAck(input string req);
    int n = 0;
    while (!ack && n < 5000) begin @(negedge clk); n++; end
    chk(ack, req, ack, 1);
  endtask

  task automatic runOp(input bit sv, input bit rs, input string req);
    int s0;
    @(negedge clk);
    s0 = shiftTotal;
    saveReq = sv; restoreReq = rs;
    @(negedge clk);
    waitAck(req);
    chk(shiftTotal - s0 == LEN, "R2 shift count", shiftTotal - s0, LEN);
    chk(!scanEn, "R8 scanEn low at ack", scanEn, 0);
    saveReq = 0; restoreReq = 0;
    @(negedge clk);
    chk(!ack, "R8 ack drops after release", ack, 0);
  endtask

  task automatic checkImage(input logic [LEN-1:0] p, input string req);
    for (int w = 0; w < NW; w++) chk(mem[w] == expWord(p, w), req, mem[w], expWord(p, w));
    chk(mem[NW] == expCrc(p), "R4 stored checksum", mem[NW], expCrc(p));
  endtask

  initial begin
    logic [LEN-1:0] pat;
    void'($urandom(32'd1234));
    rstN = 0; saveReq = 0; restoreReq = 0; memReady = 1; chain = '0; loadVal = '0;
    repeat (3) @(negedge clk);
    chk(!ack && !scanEn && !shiftEn && !memReq && !crcErr, "R1 reset outputs",
        {ack, scanEn, shiftEn, memReq, crcErr}, 0);
    rstN = 1;
    pulse(fillGo);

    // R3 R4 R5: round trips under several stall patterns
    for (int r = 0; r < 6; r++) begin
      readyMode = r % 3;
      pat = (r == 0) ? {LEN{1'b1}} : (r == 1) ? '0 : rndPat();
      setChain(pat);
      runOp(1, 0, "R3 save ack");
      checkImage(pat, "R3 packed word");
      setChain(rndPat());
      runOp(0, 1, "R5 restore ack");
      chk(chain == pat, "R5 chain restored", chain, pat);
      chk(!crcErr, "R6 clean restore no error", crcErr, 0);
    end

    // R6: corrupted data word
    readyMode = 1;
    pat = rndPat();
    setChain(pat);
    runOp(1, 0, "R6 save");
    corruptIdx = int'($urandom % NW);
    corruptMask = 32'd1 << ($urandom % 4);
    pulse(corruptGo);
    runOp(0, 1, "R6 restore corrupt");
    chk(crcErr, "R6 data corruption flagged", crcErr, 1);
    // R6: fresh save clears, then checksum word corruption
    setChain(pat);
    runOp(1, 0, "R6 resave");
    chk(!crcErr, "R6 cleared by new operation", crcErr, 0);
    corruptIdx = NW; corruptMask = 32'h8000_0000;
    pulse(corruptGo);
    runOp(0, 1, "R6 restore bad checksum");
    chk(crcErr, "R6 checksum corruption flagged", crcErr, 1);
    chk(chain == pat, "R5 data shifted despite bad checksum", chain, pat);

    // R9 + R8: both requests together, then held
    readyMode = 2;
    pulse(fillGo);
    pat = rndPat();
    setChain(pat);
    @(negedge clk);
    saveReq = 1; restoreReq = 1;
    @(negedge clk);
    waitAck("R9 simultaneous requests");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ack && !scanEn, "R8 ack held while requested", {ack, scanEn}, 2'b10);
    end
    checkImage(pat, "R9 save chosen");
    chk(!crcErr, "R8 error steady during hold", crcErr, 0);
    saveReq = 0; restoreReq = 0;
    @(negedge clk);
    chk(!ack, "R8 ack falls after release", ack, 0);

    chk(viol == 0, "R7 stall and shift rules", viol, 0);
    chk(badAddr == 0, "R3 address range", badAddr, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule